// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB panel. Its outputs are horizontal sync, vertical sync and data enable. It also reports the current pixel column and line and gives a one-cycle pulse at the start of each frame. Software describes the raster as cumulative boundaries: each field holds the running sum of every interval up to and including its own. The counters compare against these boundaries directly, so no adder sits between the configuration and the comparators.

Configuration is written through a simple write port into a shadow set of registers, and the shadow writes have no effect on the raster. A reload register copies the whole shadow set into the active set in one step. The copy happens either on the next clock or at the next frame boundary, so a timing or polarity change never tears a frame. The global enable and the output polarities belong to the same double-buffered set.

Top module: `lcd_raster_timer`

## Requirements
- R1: Register addresses (wrAddr) are 0 = sync size, 1 = accumulated back porch, 2 = accumulated active, 3 = total, 4 = control, 5 = reload. In addresses 0 to 3, bits [27:16] hold a 12-bit horizontal value and bits [10:0] hold an 11-bit vertical value. The sync size fields hold the sync width minus one.
- R2: While enabled, curX steps by one each clock from 0 up to the horizontal total inclusive, then returns to 0. Each return of curX to 0 steps curY, which returns to 0 after the vertical total.
- R3: Horizontal sync is asserted while curX is at most the horizontal sync field. Vertical sync is asserted while curY is at most the vertical sync field.
- R4: Data enable is asserted when curX is above the horizontal back porch value and at most the horizontal active value, and curY is likewise above the vertical back porch value and at most the vertical active value.
- R5: Control bits 31, 30 and 29 make hsyncOut, vsyncOut and deOut active high when set and active low when clear. Control bit 28 drives pixClkInv.
- R6: Control bit 0 is the enable. While it is clear, hsyncOut, vsyncOut and deOut sit at their inactive levels, curX and curY hold at 0, and frameStart stays low.
- R7: Writes to addresses 0 to 4 change only the shadow set and leave every output unchanged until a reload.
- R8: Writing 1 to reload bit 0 sets reloadPending[0]. On the next clock edge the shadow set is copied to the active set and that bit clears.
- R9: Writing 1 to reload bit 1 sets reloadPending[1]. The copy happens on the clock edge where the raster wraps to column 0, line 0, or on the next edge if the controller is disabled, and the bit clears at that copy.
- R10: frameStart is high for exactly the one cycle in which the counters have just wrapped from the last pixel of a frame to column 0, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| hsyncOut | output | 1 | Horizontal sync at programmed polarity |
| vsyncOut | output | 1 | Vertical sync at programmed polarity |
| deOut | output | 1 | Data enable at programmed polarity |
| pixClkInv | output | 1 | Pixel clock edge inversion select |
| frameStart | output | 1 | One-cycle frame start pulse |
| curX | output | 12 | Current pixel column |
| curY | output | 11 | Current line |
| reloadPending | output | 2 | Outstanding reload requests (bit 0 immediate, bit 1 frame boundary) |

## Verification
The assertions check on every cycle the properties that are local in time. The frame pulse may only appear at the origin. The column may only step by one or return to zero, and the line may change only when the column wraps. An immediate reload request must clear one cycle after it is taken, and a disabled controller must keep its counters at zero. Several behaviours depend on the programmed configuration and can only be shown by the bench's scenarios: the exact sync and data-enable windows, the polarity mapping, the fact that shadow writes have no effect, and the timing of the deferred reload at the frame boundary. The bench shows them by sweeping whole frames of a small raster and comparing every cycle with values computed from the boundaries.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int H_W = 12;
  localparam int V_W = 11;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int H_LSB = 16;

  localparam logic [ADDR_W-1:0] A_SYNC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_BPORCH = 3'd1;
  localparam logic [ADDR_W-1:0] A_ACTIVE = 3'd2;
  localparam logic [ADDR_W-1:0] A_TOTAL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;

  typedef struct packed {
    logic [H_W-1:0] hSync;
    logic [V_W-1:0] vSync;
    logic [H_W-1:0] hBack;
    logic [V_W-1:0] vBack;
    logic [H_W-1:0] hAct;
    logic [V_W-1:0] vAct;
    logic [H_W-1:0] hTot;
    logic [V_W-1:0] vTot;
    logic           hPolHigh;
    logic           vPolHigh;
    logic           dePolHigh;
    logic           clkInv;
    logic           enable;
  } rasterCfg_t;

  typedef struct packed {
    logic run;
  } ctrlStrobe_t;
endpackage

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameWrap,
  output rasterCfg_t        actCfg,
  output ctrlStrobe_t       strobe,
  output logic [1:0]        pending
);
  rasterCfg_t shadowCfg;
  logic       takeNow;
  logic       takeVb;
  logic       doCopy;
  logic [1:0] setReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_SYNC: begin
          shadowCfg.hSync <= wrData[H_LSB +: H_W];
          shadowCfg.vSync <= wrData[V_W-1:0];
        end
        A_BPORCH: begin
          shadowCfg.hBack <= wrData[H_LSB +: H_W];
          shadowCfg.vBack <= wrData[V_W-1:0];
        end
        A_ACTIVE: begin
          shadowCfg.hAct <= wrData[H_LSB +: H_W];
          shadowCfg.vAct <= wrData[V_W-1:0];
        end
        A_TOTAL: begin
          shadowCfg.hTot <= wrData[H_LSB +: H_W];
          shadowCfg.vTot <= wrData[V_W-1:0];
        end
        A_CTRL: begin
          shadowCfg.hPolHigh  <= wrData[31];
          shadowCfg.vPolHigh  <= wrData[30];
          shadowCfg.dePolHigh <= wrData[29];
          shadowCfg.clkInv    <= wrData[28];
          shadowCfg.enable    <= wrData[0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    takeNow = pending[0];
    takeVb  = pending[1] && (frameWrap || !actCfg.enable);
    doCopy  = takeNow || takeVb;
    setReq  = (wrEn && wrAddr == A_RELOAD) ? wrData[1:0] : 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 2'b00;
      actCfg  <= '0;
    end else begin
      pending[0] <= setReq[0] | (pending[0] & ~takeNow);
      pending[1] <= setReq[1] | (pending[1] & ~takeVb);
      if (doCopy) actCfg <= shadowCfg;
    end
  end

  assign strobe.run = actCfg.enable;
endmodule

// File: rtl/lcdt_datapath.sv
module lcdt_datapath
  import lcdt_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  rasterCfg_t     cfg,
  input  ctrlStrobe_t    strobe,
  output logic [H_W-1:0] xCnt,
  output logic [V_W-1:0] yCnt,
  output logic           frameWrap,
  output logic           frameStartQ,
  output logic           hsRaw,
  output logic           vsRaw,
  output logic           deRaw
);
  logic lineEnd;
  logic frameEnd;

  always_comb begin
    lineEnd   = xCnt >= cfg.hTot;
    frameEnd  = yCnt >= cfg.vTot;
    frameWrap = strobe.run && lineEnd && frameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt        <= '0;
      yCnt        <= '0;
      frameStartQ <= 1'b0;
    end else if (!strobe.run) begin
      xCnt        <= '0;
      yCnt        <= '0;
      frameStartQ <= 1'b0;
    end else begin
      frameStartQ <= frameWrap;
      if (lineEnd) begin
        xCnt <= '0;
        yCnt <= frameEnd ? '0 : yCnt + 1'b1;
      end else begin
        xCnt <= xCnt + 1'b1;
      end
    end
  end

  always_comb begin
    hsRaw = strobe.run && (xCnt <= cfg.hSync);
    vsRaw = strobe.run && (yCnt <= cfg.vSync);
    deRaw = strobe.run && (xCnt > cfg.hBack) && (xCnt <= cfg.hAct)
            && (yCnt > cfg.vBack) && (yCnt <= cfg.vAct);
  end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pixClkInv,
  output logic              frameStart,
  output logic [H_W-1:0]    curX,
  output logic [V_W-1:0]    curY,
  output logic [1:0]        reloadPending
);
  rasterCfg_t  actCfg;
  ctrlStrobe_t strobe;
  logic        frameWrap;
  logic        hsRaw;
  logic        vsRaw;
  logic        deRaw;

  lcdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameWrap(frameWrap), .actCfg(actCfg), .strobe(strobe),
    .pending(reloadPending)
  );

  lcdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(actCfg), .strobe(strobe),
    .xCnt(curX), .yCnt(curY), .frameWrap(frameWrap),
    .frameStartQ(frameStart), .hsRaw(hsRaw), .vsRaw(vsRaw), .deRaw(deRaw)
  );

  assign hsyncOut  = actCfg.hPolHigh  ? hsRaw : ~hsRaw;
  assign vsyncOut  = actCfg.vPolHigh  ? vsRaw : ~vsRaw;
  assign deOut     = actCfg.dePolHigh ? deRaw : ~deRaw;
  assign pixClkInv = actCfg.clkInv;
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker
  import lcdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              frameStart,
  input logic [H_W-1:0]    curX,
  input logic [V_W-1:0]    curY,
  input logic [1:0]        reloadPending,
  input logic              runNow
);
  AST_FS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (curX == '0 && curY == '0)); // R10

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (curX != '0) |=> (curX == $past(curX) + 1'b1 || curX == '0)); // R2

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (curX != '0) |-> $stable(curY)); // R2

  AST_IMM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (reloadPending[0] && !(wrEn && wrAddr == A_RELOAD && wrData[0]))
      |=> !reloadPending[0]); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!runNow && $past(!runNow)) |-> (curX == '0 && curY == '0 && !frameStart)); // R6
endmodule

bind lcd_raster_timer lcdt_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .frameStart(frameStart), .curX(curX), .curY(curY),
  .reloadPending(reloadPending), .runNow(strobe.run)
);

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        hsyncOut, vsyncOut, deOut, pixClkInv, frameStart;
  logic [11:0] curX;
  logic [10:0] curY;
  logic [1:0]  reloadPending;

  int checks = 0;
  int errors = 0;

  lcd_raster_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixClkInv(pixClkInv), .frameStart(frameStart), .curX(curX),
    .curY(curY), .reloadPending(reloadPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int hs, vs, hb, vb, ha, va, ht, vt;
    bit hp, vp, dp, ci;
  } cfg_t;

  cfg_t cfgExp, cfgNext;
  bit   monOn = 0, havePrev = 0, swapAtFrame = 0;
  int   px, py, framesSeen = 0;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadCfg(input cfg_t c);
    wr(3'd0, 32'(c.hs) << 16 | 32'(c.vs));
    wr(3'd1, 32'(c.hb) << 16 | 32'(c.vb));
    wr(3'd2, 32'(c.ha) << 16 | 32'(c.va));
    wr(3'd3, 32'(c.ht) << 16 | 32'(c.vt));
    wr(3'd4, {c.hp, c.vp, c.dp, c.ci, 27'd0, 1'b1});
  endtask

  function automatic bit lvl(input bit act, input bit pol);
    return pol ? act : !act;
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      if (havePrev) begin
        int ex, ey;
        bit ef;
        ef = (px >= cfgExp.ht) && (py >= cfgExp.vt);
        if (px >= cfgExp.ht) begin
          ex = 0; ey = (py >= cfgExp.vt) ? 0 : py + 1;
        end else begin
          ex = px + 1; ey = py;
        end
        chk("R2", curX, ex, "curX");
        chk("R2", curY, ey, "curY");
        chk("R10", frameStart, ef, "frameStart");
      end
      if (frameStart) begin
        framesSeen++;
        if (swapAtFrame) begin
          chk("R9", reloadPending[1], 0, "deferred reload cleared at frame");
          cfgExp = cfgNext;
          swapAtFrame = 0;
        end
      end else if (swapAtFrame) begin
        chk("R9", reloadPending[1], 1, "deferred reload still pending");
      end
      chk("R3", hsyncOut, lvl(int'(curX) <= cfgExp.hs, cfgExp.hp), "hsync");
      chk("R3", vsyncOut, lvl(int'(curY) <= cfgExp.vs, cfgExp.vp), "vsync");
      chk("R4", deOut, lvl(int'(curX) > cfgExp.hb && int'(curX) <= cfgExp.ha &&
                           int'(curY) > cfgExp.vb && int'(curY) <= cfgExp.va, cfgExp.dp), "de");
      chk("R5", pixClkInv, cfgExp.ci, "pixClkInv");
      px = curX; py = curY; havePrev = 1;
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_t a, b;
    // sync 2/1, back porch 2/1, active 4/3, front porch 2/1: R1 cumulative encoding
    a = '{hs:1, vs:0, hb:3, vb:1, ha:7, va:4, ht:9, vt:5, hp:0, vp:0, dp:0, ci:0};
    b = '{hs:0, vs:1, hb:2, vb:2, ha:5, va:4, ht:7, vt:6, hp:1, vp:1, dp:1, ci:1};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6", hsyncOut, 1, "reset hsync inactive");
    chk("R6", vsyncOut, 1, "reset vsync inactive");
    chk("R6", deOut, 1, "reset de inactive");
    chk("R6", curX, 0, "reset curX");
    chk("R6", frameStart, 0, "reset frameStart");
    chk("R8", reloadPending, 0, "reset pending");

    loadCfg(a);
    repeat (4) @(negedge clk);
    chk("R7", curX, 0, "shadow write no effect on curX");
    chk("R7", hsyncOut, 1, "shadow write no effect on hsync");
    chk("R7", pixClkInv, 0, "shadow write no effect on pixClkInv");

    wr(3'd5, 32'h1);
    chk("R8", reloadPending[0], 1, "immediate request pending");
    cfgExp = a;
    @(posedge clk); #1;
    monOn = 1;
    @(negedge clk); #1;
    chk("R8", reloadPending[0], 0, "immediate request cleared");
    chk("R1", curX, 0, "start at column 0");
    repeat (2 * 60) @(negedge clk);

    // deferred reload with new geometry and all polarities high
    cfgNext = b;
    loadCfg(b);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd5; wrData = 32'h2;
    @(posedge clk); #1;
    wrEn = 1'b0;
    swapAtFrame = 1;
    repeat (3 * 72) @(negedge clk);
    chk("R9", swapAtFrame, 0, "deferred reload applied");
    chk("R10", framesSeen >= 4, 1, "frame pulses seen");

    // disable with immediate reload
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd4; wrData = {4'b1111, 28'd0};
    @(negedge clk);
    monOn = 0;
    wrAddr = 3'd5; wrData = 32'h1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk("R6", hsyncOut, 0, "disabled hsync inactive low");
      chk("R6", vsyncOut, 0, "disabled vsync inactive low");
      chk("R6", deOut, 0, "disabled de inactive low");
      chk("R6", curX, 0, "disabled curX");
      chk("R6", frameStart, 0, "disabled frameStart");
      @(negedge clk);
    end

    // deferred reload while disabled takes effect on the next edge
    loadCfg(a);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd5; wrData = 32'h2;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R9", reloadPending[1], 1, "deferred request pending while disabled");
    @(negedge clk);
    chk("R9", reloadPending[1], 0, "deferred request cleared while disabled");
    chk("R5", hsyncOut, 0, "active low hsync restored");
    repeat (2) @(negedge clk);
    chk("R2", curX, 2, "counting resumed");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule